// File: doc/BRIEF.md
# Phase-Paced Pin Streamer

The block streams items between a small local buffer and a 32-bit pin bus. The pace comes from a numerically controlled oscillator. On every clock while streaming, a 32-bit rate word is added into a phase accumulator. A transfer happens on each clock where that sum reaches the half-scale point (2^31 or above). Only the low 31 bits of the sum are kept, so the fractional part of the rate carries from one transfer into the next. A rate word of 2^31 moves one item per clock, 2^30 moves one every second clock, and 0x2AAAAAAB moves one every third clock. The last of these is rounded up in its lowest bit so that the third sum crosses the threshold.

Software-facing logic loads the rate word, the item size, the direction and the item count, then pulses `start`. In output mode, each transfer reads the next buffer entry and writes its low byte, low halfword or full word onto the pins. Pins outside the selected item keep their value. In input mode, each transfer samples the pins, zero-extends them to the item size and writes the result into the next buffer entry. When the programmed number of items has moved, the block raises `done` for one cycle and goes back to idle.

The control is a three-state machine. IDLE waits for `start`. On `start` it goes to FIN when the count is zero, and to RUN otherwise. RUN advances the accumulator every clock and goes to FIN on the transfer that moves the last item. FIN lasts one cycle and always returns to IDLE.

Top module: `pin_streamer`

## Requirements
- R1: After reset, `pins_out`, `xfer`, `busy`, `done` and `buf_we` are all 0.
- R2: A `start` pulse in IDLE latches the configuration and clears the accumulator. On every following clock in RUN, the rate word is added to the accumulator and the low 31 bits of the sum are kept. A transfer fires on each clock where the sum is at least 2^31. `xfer` is high for the one cycle after that clock edge.
- R3: Rate 0x80000000 transfers on every clock. Rate 0x40000000 transfers on every second clock. Rate 0x2AAAAAAB makes its first transfer on the third clock, then one every third clock.
- R4: A rate word of zero never transfers, and `busy` stays high.
- R5: `cfg_size` selects the item size: 0 is a byte, 1 is a 16-bit word, and 2 or 3 is a 32-bit long. In output mode (`cfg_dir`=0), a transfer replaces only pins [7:0], [15:0] or [31:0] with the buffer word. The other pins hold their value.
- R6: In input mode (`cfg_dir`=1), each transfer writes to buffer entry k, where k is the item index starting at 0. It asserts `buf_we` in the same cycle as `xfer`, with `buf_wdata` set to the pins sampled at the firing edge, masked to the item size and zero-extended.
- R7: In output mode, item k is read from buffer entry k. `buf_raddr` presents the index, and `buf_rdata` is read without a register in between.
- R8: `done` is high for exactly one cycle, coinciding with the `xfer` of the last item, and `busy` is low from the next cycle on. A count of zero gives `done` in the cycle after `start`, with no transfer.
- R9: `start` is ignored while streaming or while `done` is high.
- R10: `buf_we` is never asserted in output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a stream (honoured in IDLE) |
| cfg_freq | input | 32 | Phase rate word |
| cfg_size | input | 2 | Item size: 0 byte, 1 word, 2/3 long |
| cfg_dir | input | 1 | 0 output to pins, 1 capture from pins |
| cfg_count | input | ADDR_W+1 | Number of items to move |
| pins_in | input | 32 | Pin states to capture |
| pins_out | output | 32 | Driven pin bus |
| xfer | output | 1 | Transfer strobe |
| busy | output | 1 | High in RUN |
| done | output | 1 | One-cycle completion pulse |
| buf_raddr | output | ADDR_W | Buffer read address (item index) |
| buf_rdata | input | 32 | Buffer read data, same cycle |
| buf_we | output | 1 | Buffer write enable |
| buf_waddr | output | ADDR_W | Buffer write address |
| buf_wdata | output | 32 | Buffer write data |

## Verification
The properties assume that the buffer returns read data in the same cycle the address is presented. They also assume that `start` only matters in IDLE, because the latched configuration is what they reason about. The stimulus keeps the random rate words at or above 2^24 and the counts no larger than the buffer, so every stream ends well inside the run. The zero-rate case is driven on its own and cleared with a reset, since that stream never ends. Mid-stream `start` pulses carry a different configuration so that any leakage of `start` shows up at the pins.

// File: rtl/pstream_pkg.sv
package pstream_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } item_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } stream_state_e;

endpackage

// File: rtl/pstream_nco.sv
module pstream_nco #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [ACC_W-1:0] rate,
    output logic             fire
);
    // Kept phase drops the top bit; the sum needs one extra bit for the
    // case where a large phase meets a large rate.
    localparam int KEEP_W = ACC_W - 1;
    localparam int SUM_W  = ACC_W + 1;

    logic [KEEP_W-1:0] phase;
    logic [SUM_W-1:0]  sum;

    assign sum  = {2'b00, phase} + {1'b0, rate};
    assign fire = advance && (sum[SUM_W-1:KEEP_W] != 2'b00);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clear) begin
            phase <= '0;
        end else if (advance) begin
            phase <= sum[KEEP_W-1:0];
        end
    end

endmodule

// File: rtl/pstream_lanes.sv
module pstream_lanes #(
    parameter int LANES = 4
) (
    input  logic [1:0]         size,
    input  logic [LANES*8-1:0] held,
    input  logic [LANES*8-1:0] fresh,
    input  logic [LANES*8-1:0] sampled,
    output logic [LANES*8-1:0] merged,
    output logic [LANES*8-1:0] captured
);
    import pstream_pkg::*;

    logic [LANES-1:0] lane_on;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == 0) begin : g_low
            assign lane_on[k] = 1'b1;
        end else if (k == 1) begin : g_mid
            assign lane_on[k] = size[1] || (item_size_e'(size) == SZ_WORD);
        end else begin : g_high
            assign lane_on[k] = size[1];
        end
        assign merged[k*8 +: 8]   = lane_on[k] ? fresh[k*8 +: 8] : held[k*8 +: 8];
        assign captured[k*8 +: 8] = lane_on[k] ? sampled[k*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/pin_streamer.sv
module pin_streamer #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [31:0]         cfg_freq,
    input  logic [1:0]          cfg_size,
    input  logic                cfg_dir,
    input  logic [ADDR_W:0]     cfg_count,
    input  logic [LANES*8-1:0]  pins_in,
    output logic [LANES*8-1:0]  pins_out,
    output logic                xfer,
    output logic                busy,
    output logic                done,
    output logic [ADDR_W-1:0]   buf_raddr,
    input  logic [LANES*8-1:0]  buf_rdata,
    output logic                buf_we,
    output logic [ADDR_W-1:0]   buf_waddr,
    output logic [LANES*8-1:0]  buf_wdata
);
    import pstream_pkg::*;

    localparam int DATA_W = LANES * 8;
    localparam int CNT_W  = ADDR_W + 1;

    stream_state_e state, state_nx;

    logic [31:0]       freq_q;
    logic [1:0]        size_q;
    logic              dir_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  idx;
    logic              fire;
    logic              last_item;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] captured;

    pstream_nco #(.ACC_W(32)) u_nco (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == ST_IDLE),
        .advance (state == ST_RUN),
        .rate    (freq_q),
        .fire    (fire)
    );

    pstream_lanes #(.LANES(LANES)) u_lanes (
        .size     (size_q),
        .held     (pins_out),
        .fresh    (buf_rdata),
        .sampled  (pins_in),
        .merged   (merged),
        .captured (captured)
    );

    assign last_item = (idx + CNT_W'(1)) == count_q;
    assign buf_raddr = idx[ADDR_W-1:0];
    assign busy      = (state == ST_RUN);
    assign done      = (state == ST_FIN);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = (cfg_count == '0) ? ST_FIN : ST_RUN;
            ST_RUN:  if (fire && last_item) state_nx = ST_FIN;
            ST_FIN:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q    <= '0;
            size_q    <= '0;
            dir_q     <= 1'b0;
            count_q   <= '0;
            idx       <= '0;
            pins_out  <= '0;
            xfer      <= 1'b0;
            buf_we    <= 1'b0;
            buf_waddr <= '0;
            buf_wdata <= '0;
        end else begin
            xfer   <= 1'b0;
            buf_we <= 1'b0;
            if (state == ST_IDLE && start) begin
                freq_q  <= cfg_freq;
                size_q  <= cfg_size;
                dir_q   <= cfg_dir;
                count_q <= cfg_count;
                idx     <= '0;
            end
            if (fire) begin
                xfer <= 1'b1;
                idx  <= idx + CNT_W'(1);
                if (dir_q) begin
                    buf_we    <= 1'b1;
                    buf_waddr <= idx[ADDR_W-1:0];
                    buf_wdata <= captured;
                end else begin
                    pins_out  <= merged;
                end
            end
        end
    end

endmodule

// File: rtl/pin_streamer_chk.sv
module pin_streamer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer,
    input logic              busy,
    input logic              done,
    input logic              buf_we,
    input logic [DATA_W-1:0] pins_out,
    input logic [31:0]       freq_q,
    input logic [1:0]        size_q,
    input logic              dir_q
);

    a_r2_xfer_follows_run: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> $past(busy));

    a_r3_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && freq_q == 32'h8000_0000) |=> xfer);

    a_r4_zero_rate_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && freq_q == 32'd0) |=> !xfer);

    a_r5_upper_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !dir_q && size_q == 2'd0) |-> pins_out[DATA_W-1:8] == $past(pins_out[DATA_W-1:8]));

    a_r6_write_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> xfer);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r10_no_write_in_output: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> dir_q);

endmodule

bind pin_streamer pin_streamer_chk #(.DATA_W(LANES*8)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer     (xfer),
    .busy     (busy),
    .done     (done),
    .buf_we   (buf_we),
    .pins_out (pins_out),
    .freq_q   (freq_q),
    .size_q   (size_q),
    .dir_q    (dir_q)
);

// File: tb/sim_pin_streamer.sv
module sim_pin_streamer;

    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       cfg_freq = '0;
    logic [1:0]        cfg_size = '0;
    logic              cfg_dir = 1'b0;
    logic [ADDR_W:0]   cfg_count = '0;
    logic [31:0]       pins_in = '0;
    logic [31:0]       pins_out;
    logic              xfer, busy, done, buf_we;
    logic [ADDR_W-1:0] buf_raddr, buf_waddr;
    logic [31:0]       buf_rdata, buf_wdata;
    logic [31:0]       mem [DEPTH];

    int nchk = 0;
    int nerr = 0;
    logic [31:0] exp_pins = '0;

    always #2 clk = ~clk;

    assign buf_rdata = mem[buf_raddr];

    pin_streamer #(.ADDR_W(ADDR_W), .LANES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_freq(cfg_freq),
        .cfg_size(cfg_size), .cfg_dir(cfg_dir), .cfg_count(cfg_count),
        .pins_in(pins_in), .pins_out(pins_out), .xfer(xfer), .busy(busy),
        .done(done), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata)
    );

    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        if (sz[1])       return 32'hFFFF_FFFF;
        else if (sz[0])  return 32'h0000_FFFF;
        else             return 32'h0000_00FF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_pins = '0;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = $urandom;
    endtask

    // Runs one stream against a bench model of the phase accumulator.
    task automatic run_stream(input logic dir, input logic [1:0] sz, input logic [31:0] rate,
                              input int count, input int mid_start, input string tag);
        logic [30:0] macc;
        logic [32:0] sum;
        logic [31:0] drive;
        logic [31:0] m;
        logic        f;
        int          moved;
        int          cyc;
        bit          fin;
        m = size_mask(sz);
        macc = '0;
        moved = 0;
        cyc = 0;
        fin = 0;
        @(negedge clk);
        cfg_dir = dir; cfg_size = sz; cfg_freq = rate;
        cfg_count = (ADDR_W+1)'(count);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (count == 0) begin
            check("R8 done after zero count", {31'd0, done}, 32'd1);
            check("R8 no xfer on zero count", {31'd0, xfer}, 32'd0);
            @(negedge clk);
            check("R8 idle after zero count", {30'd0, busy, done}, 32'd0);
            return;
        end
        check("R2 busy after start", {31'd0, busy}, 32'd1);
        while (!fin && cyc < 6000) begin
            drive = $urandom;
            pins_in = drive;
            if (cyc == mid_start) begin
                start = 1'b1; cfg_dir = ~dir; cfg_size = ~sz;
                cfg_freq = 32'h8000_0000; cfg_count = 1;
            end
            sum = {2'b00, macc} + {1'b0, rate};
            f = (sum[32:31] != 2'b00);
            macc = sum[30:0];
            @(negedge clk);
            start = 1'b0;
            check({tag, " xfer timing"}, {31'd0, xfer}, {31'd0, f});
            if (f) begin
                if (!dir) begin
                    exp_pins = (exp_pins & ~m) | (mem[moved] & m);
                    check("R7 R5 pins from buffer entry", pins_out, exp_pins);
                end else begin
                    check("R6 write enable", {31'd0, buf_we}, 32'd1);
                    check("R6 write address", {24'd0, buf_waddr}, moved);
                    check("R6 captured data", buf_wdata, drive & m);
                end
                moved++;
                if (moved == count) begin
                    check("R8 done with last item", {31'd0, done}, 32'd1);
                    fin = 1;
                end
            end
            if (!fin) check("R8 no early done", {31'd0, done}, 32'd0);
            if (!dir) begin
                check("R10 no write in output mode", {31'd0, buf_we}, 32'd0);
                check("R5 held pins", pins_out, exp_pins);
            end
            cyc++;
        end
        check("R8 stream completed", {31'd0, fin}, 32'd1);
        @(negedge clk);
        check("R8 idle after done", {30'd0, busy, done}, 32'd0);
        check("R9 no extra xfer", {31'd0, xfer}, 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        nerr++; nchk++;
        $display("FAIL watchdog expired R8 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250));
        fill_mem();
        do_reset();
        check("R1 reset pins", pins_out, 32'd0);
        check("R1 reset strobes", {28'd0, xfer, busy, done, buf_we}, 32'd0);

        run_stream(1'b0, 2'd2, 32'h8000_0000, 5, -1, "R3 every clock");
        run_stream(1'b1, 2'd1, 32'h4000_0000, 4, -1, "R3 every second");
        run_stream(1'b0, 2'd0, 32'h2AAA_AAAB, 4, -1, "R3 every third");
        run_stream(1'b0, 2'd1, 32'hFFFF_FFFF, 6, -1, "R2 max rate");
        run_stream(1'b0, 2'd3, 32'h1234_5678, 3, -1, "R5 size three");
        run_stream(1'b0, 2'd0, 32'd0, 0, -1, "R8 zero count");
        run_stream(1'b0, 2'd0, 32'h3000_0001, 6, 2, "R9 mid start");
        run_stream(1'b1, 2'd2, 32'h2000_0000, 5, 6, "R9 mid start input");
        run_stream(1'b1, 2'd2, 32'h8000_0000, DEPTH, -1, "R6 full buffer");

        for (int r = 0; r < 14; r++) begin
            logic [31:0] rate;
            rate = $urandom | 32'h0100_0000;
            fill_mem();
            run_stream(1'($urandom), 2'($urandom), rate, 1 + ($urandom % 20), -1, "R2 random");
        end

        @(negedge clk);
        cfg_freq = 32'd0; cfg_count = 4; cfg_dir = 1'b0; cfg_size = 2'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 60; c++) begin
            check("R4 zero rate no xfer", {31'd0, xfer}, 32'd0);
            check("R4 zero rate still busy", {31'd0, busy}, 32'd1);
            @(negedge clk);
        end
        do_reset();
        check("R1 pins cleared by reset", pins_out, 32'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule